// File: doc/BRIEF.md
# Destination IP to MAC Nibble Lookup Table

This block is a small content-addressable table on the egress path of a line card. Each entry holds a 32-bit IPv4 destination address and a 4-bit value. For each packet, the destination IP address is presented as a search key. The block returns a hit or miss indication and a 4-bit nibble. It also returns a full 48-bit destination MAC address. That address is the card's own local MAC with only its lowest nibble replaced by the search result.

The table is filled from a stream of 64-bit initialisation words. A load starts with a start pulse and an entry count. Words are then written to consecutive entries, beginning at entry 0. The load stops when the count is reached or when a word flagged as last arrives. While a load is running, lookups are refused and flagged as rejected. Outside a load, one lookup may be issued per clock, and each result appears on the following clock.

Top module: `ipmac_cam`

## Requirements
- R1: After reset the block is idle (`init_busy` low), no response or reject is flagged, and every entry is invalid, so any lookup misses.
- R2: An init word is decoded with the key in bits [63:32] and the nibble in bits [3:0]. Bits [31:4] are reserved and have no effect on the stored entry.
- R3: A start pulse clears every entry. `init_busy` is high from the next cycle. Each accepted word fills the next entry, starting at 0. The load ends after min(`init_count`, 16) words, or after a word with `init_last` set. A count of 0 ends the load one cycle after it starts. Entries that were not written stay invalid.
- R4: A lookup accepted in cycle N produces `rsp_valid` high in cycle N+1 only. With no lookup presented, neither `rsp_valid` nor `rsp_reject` is raised.
- R5: On a hit, `rsp_hit`=1, `rsp_miss`=0, and `rsp_nibble` equals the nibble stored in the matching entry.
- R6: On a miss, `rsp_miss`=1, `rsp_hit`=0, and `rsp_nibble` equals bits [3:0] of `local_mac`.
- R7: `rsp_mac` equals `local_mac` with bits [3:0] replaced by `rsp_nibble`.
- R8: When several valid entries hold the same key, the lowest-numbered entry supplies the nibble.
- R9: A lookup presented while `init_busy` is high raises `rsp_reject` in the next cycle, leaves `rsp_valid` low, and does not alter the table.
- R10: Init words presented while no load is running are ignored and change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | The card's own MAC address |
| init_start | input | 1 | Pulse that starts a table load (ignored while a load is running) |
| init_count | input | 5 | Number of entries to load, capped at the table depth |
| init_valid | input | 1 | An init word is present |
| init_word | input | 64 | Init word: key, reserved bits, nibble |
| init_last | input | 1 | Marks the final word of the stream |
| init_busy | output | 1 | A load is in progress |
| lk_valid | input | 1 | A lookup key is present |
| lk_key | input | 32 | Destination IPv4 address to search for |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_reject | output | 1 | The previous cycle's lookup was refused |
| rsp_hit | output | 1 | The key matched an entry |
| rsp_miss | output | 1 | The key matched no entry |
| rsp_nibble | output | 4 | Returned MAC nibble |
| rsp_mac | output | 48 | Assembled destination MAC |

## Verification
The bench builds the block with its default parameters: 16 entries, 32-bit keys, 4-bit nibbles, a 48-bit MAC and 64-bit init words. At 16 entries, a full load and an over-limit count are both cheap to reach. The bench can therefore drive the count cap, a stray word after the table is full, an early stop on the last flag, and a zero count. The small depth also lets duplicate keys at low indices exercise the priority rule, and lets lookups issued mid-load hit the reject path.

// File: rtl/ipmac_cam.sv
module ipmac_cam #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int NIB_W   = 4,
  parameter int MAC_W   = 48,
  parameter int WORD_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAC_W-1:0]  local_mac,
  input  logic              init_start,
  input  logic [CNT_W-1:0]  init_count,
  input  logic              init_valid,
  input  logic [WORD_W-1:0] init_word,
  input  logic              init_last,
  output logic              init_busy,
  input  logic              lk_valid,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              rsp_valid,
  output logic              rsp_reject,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [NIB_W-1:0]  rsp_nibble,
  output logic [MAC_W-1:0]  rsp_mac
);

  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [NIB_W-1:0]   nib_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [CNT_W-1:0]   ptr_q, limit_q;
  logic               busy_q;

  wire [CNT_W-1:0]  limit_in = (init_count > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : init_count;
  wire              accept   = busy_q && init_valid && (ptr_q != limit_q);
  wire              finish   = busy_q && ((ptr_q == limit_q) ||
                               (accept && (init_last || (ptr_q + CNT_W'(1) == limit_q))));
  wire [KEY_W-1:0]  in_key   = init_word[WORD_W-1 -: KEY_W];
  wire [NIB_W-1:0]  in_nib   = init_word[NIB_W-1:0];
  wire              unused_rsvd = ^init_word[WORD_W-KEY_W-1:NIB_W];
  wire              take     = lk_valid && !busy_q;

  assign init_busy = busy_q;

  logic [ENTRIES-1:0] match;
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (key_q[g] == lk_key);
    end
  endgenerate

  logic             hit;
  logic [NIB_W-1:0] sel_nib;
  always_comb begin
    hit     = 1'b0;
    sel_nib = local_mac[NIB_W-1:0];
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        sel_nib = nib_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      limit_q <= '0;
      vld_q   <= '0;
    end else if (!busy_q && init_start) begin
      busy_q  <= 1'b1;
      ptr_q   <= '0;
      limit_q <= limit_in;
      vld_q   <= '0;
    end else begin
      if (accept) begin
        vld_q[ptr_q[IDX_W-1:0]] <= 1'b1;
        ptr_q <= ptr_q + CNT_W'(1);
      end
      if (finish) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      key_q[ptr_q[IDX_W-1:0]] <= in_key;
      nib_q[ptr_q[IDX_W-1:0]] <= in_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_nibble <= '0;
      rsp_mac    <= '0;
    end else begin
      rsp_valid  <= take;
      rsp_reject <= lk_valid && busy_q;
      rsp_hit    <= take && hit;
      rsp_miss   <= take && !hit;
      rsp_nibble <= sel_nib;
      rsp_mac    <= {local_mac[MAC_W-1:NIB_W], sel_nib};
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !init_busy) |=> (rsp_valid && !rsp_reject));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_reject));
  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && init_busy) |=> (rsp_reject && !rsp_valid));
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  assert_miss_nib_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_nibble == $past(local_mac[NIB_W-1:0])));
  assert_mac_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_mac == {$past(local_mac[MAC_W-1:NIB_W]), rsp_nibble}));
  assert_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (ptr_q <= limit_q && limit_q <= CNT_W'(ENTRIES)));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && !init_start) |=> $stable(vld_q));

endmodule

// File: tb/ipmac_cam_tb.sv
module ipmac_cam_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [47:0] local_mac = 48'h0A0B0C0D0E05;
  logic        init_start = 0;
  logic [4:0]  init_count = 0;
  logic        init_valid = 0;
  logic [63:0] init_word = 0;
  logic        init_last = 0;
  logic        init_busy;
  logic        lk_valid = 0;
  logic [31:0] lk_key = 0;
  logic        rsp_valid, rsp_reject, rsp_hit, rsp_miss;
  logic [3:0]  rsp_nibble;
  logic [47:0] rsp_mac;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  ipmac_cam u_dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] k, input logic [27:0] rsv, input logic [3:0] n);
    return {k, rsv, n};
  endfunction

  task automatic start_load(input logic [4:0] cnt);
    @(negedge clk); init_start = 1; init_count = cnt;
    @(negedge clk); init_start = 0;
  endtask

  task automatic push(input logic [63:0] w, input logic last);
    init_valid = 1; init_word = w; init_last = last;
    @(negedge clk); init_valid = 0; init_last = 0;
  endtask

  task automatic lookup(input string req, input logic [31:0] k, input logic exp_hit, input logic [3:0] exp_nib);
    lk_valid = 1; lk_key = k;
    @(negedge clk); lk_valid = 0;
    chk({req, " valid"}, 48'(rsp_valid), 48'd1);
    chk({req, " hit"}, 48'(rsp_hit), 48'(exp_hit));
    chk({req, " miss"}, 48'(rsp_miss), 48'(!exp_hit));
    chk({req, " nibble"}, 48'(rsp_nibble), 48'(exp_nib));
    chk({req, " mac R7"}, rsp_mac, {local_mac[47:4], exp_nib});
    @(negedge clk);
    chk({req, " single pulse R4"}, 48'(rsp_valid), 48'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 48'(init_busy), 48'd0);
    chk("R1 valid", 48'(rsp_valid), 48'd0);
    chk("R1 reject", 48'(rsp_reject), 48'd0);
    lookup("R1 R6 empty", 32'h0, 1'b0, 4'h5);
  endtask

  task automatic t_basic();
    start_load(5'd4);
    chk("R3 busy after start", 48'(init_busy), 48'd1);
    push(mk(32'hC0A80001, 28'h0, 4'h1), 0);
    push(mk(32'hC0A80002, 28'hFFFFFFF, 4'h2), 0);
    push(mk(32'hC0A80001, 28'h0, 4'h3), 0);
    chk("R3 busy mid-load", 48'(init_busy), 48'd1);
    push(mk(32'hC0A80003, 28'h1234567, 4'h0), 0);
    chk("R3 done at count", 48'(init_busy), 48'd0);
    lookup("R8 R5 dup key", 32'hC0A80001, 1'b1, 4'h1);
    lookup("R2 reserved ignored", 32'hC0A80002, 1'b1, 4'h2);
    lookup("R5 R7 zero nib", 32'hC0A80003, 1'b1, 4'h0);
    lookup("R6 miss", 32'hC0A80009, 1'b0, 4'h5);
  endtask

  task automatic t_reject();
    start_load(5'd2);
    lk_valid = 1; lk_key = 32'hC0A80002;
    @(negedge clk); lk_valid = 0;
    chk("R9 reject", 48'(rsp_reject), 48'd1);
    chk("R9 no valid", 48'(rsp_valid), 48'd0);
    push(mk(32'h0A000001, 28'h0, 4'h7), 0);
    push(mk(32'h0A000002, 28'h0, 4'h8), 0);
    chk("R3 done", 48'(init_busy), 48'd0);
    lookup("R3 cleared by start", 32'hC0A80001, 1'b0, 4'h5);
    lookup("R9 table intact", 32'h0A000002, 1'b1, 4'h8);
  endtask

  task automatic t_last();
    start_load(5'd16);
    push(mk(32'h0B000001, 28'h0, 4'h9), 0);
    push(mk(32'h0B000002, 28'h0, 4'hA), 0);
    push(mk(32'h0B000003, 28'h0, 4'hB), 1);
    chk("R3 stop on last", 48'(init_busy), 48'd0);
    lookup("R3 last entry", 32'h0B000003, 1'b1, 4'hB);
  endtask

  task automatic t_stray();
    push(mk(32'h0C000001, 28'h0, 4'hC), 0);
    lookup("R10 stray idle word", 32'h0C000001, 1'b0, 4'h5);
  endtask

  task automatic t_full();
    start_load(5'd20);
    for (int i = 0; i < 16; i++) begin
      chk("R3 busy during full", 48'(init_busy), 48'd1);
      push(mk(32'h10000000 + i, 28'h0, 4'(i)), 0);
    end
    chk("R3 count capped", 48'(init_busy), 48'd0);
    push(mk(32'h20000000, 28'h0, 4'hE), 0);
    lookup("R3 entry 15", 32'h1000000F, 1'b1, 4'hF);
    lookup("R3 entry 0", 32'h10000000, 1'b1, 4'h0);
    lookup("R10 stray after full", 32'h20000000, 1'b0, 4'h5);
  endtask

  task automatic t_zero();
    start_load(5'd0);
    chk("R3 zero busy", 48'(init_busy), 48'd1);
    @(negedge clk);
    chk("R3 zero done", 48'(init_busy), 48'd0);
    lookup("R3 zero empty", 32'h10000003, 1'b0, 4'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reject();
    t_last();
    t_stray();
    t_full();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule